// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This unit works on one contiguous bit field inside a 32-bit word. The field is named by the index of its most significant bit and by its width in bits. For example, top bit 9 with width 8 covers bits 9 down to 2. In extract mode the unit returns the field moved down to bit 0, with every bit above it cleared. In insert mode it takes a destination word and a source value and returns the destination with only the field's bits replaced by the low bits of the source.

A request is offered with a valid/ready handshake and carries the mode, the field's top bit and width, the destination (or extract) word and the source value. The result sits in a single output register. It appears the cycle after the request is accepted and is held until the consumer takes it. A field whose width is zero or larger than the word, or whose low end would fall below bit 0, sets an error flag and returns the input word unchanged.

Top module: `bfu_top`

## Requirements
- R1: In extract mode (mode = 0) with a legal field, the result holds field bit k in result bit k for k below the width, and every result bit at or above the width is 0.
- R2: In insert mode (mode = 1) with a legal field, the field bits of the result come from source bits 0 up to width-1. Every destination bit outside the field passes through unchanged.
- R3: In insert mode, source bits at or above the field width have no effect on the result.
- R4: A full-word field (top bit 31, width 32) is legal. Extract returns the whole word, and insert returns the whole source.
- R5: Fields lying partly or fully in bits 16 to 31 are extracted and inserted correctly, including a single-bit field at bit 31.
- R6: A request whose width is 0, whose width is above 32, or whose top bit is less than width-1 returns the input word unchanged with the error flag set to 1. Legal requests return the error flag as 0.
- R7: The response becomes valid in the cycle after a request is accepted (request valid and ready both high at a clock edge).
- R8: While a response is valid and the consumer is not ready, the response data and error flag stay constant and the unit reports not ready.
- R9: After reset no response is valid and the unit is ready.
- R10: Responses leave in the order their requests were accepted. A new request can be accepted in the same cycle that the previous response is taken, without losing either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit can accept a request |
| req_mode | input | 1 | 0 = extract, 1 = insert |
| req_left | input | 5 | Index of the field's most significant bit |
| req_size | input | 6 | Field width in bits (legal 1 to 32) |
| req_word | input | 32 | Word to extract from, or destination for insert |
| req_src | input | 32 | New field value in its low bits (insert only) |
| rsp_valid | output | 1 | Result register holds a response |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32 | Extracted field or updated word |
| rsp_err | output | 1 | Field specification was illegal |

## Verification
Accepting a new request and draining the held response can happen at the same clock edge. The output register must then load the new result rather than clear its valid flag. The bench provokes this by keeping requests back to back while it toggles the consumer's ready at random, so hand-overs, stalls and idle gaps all mix. Each accepted request pushes a model result onto a queue, and each drained response must match the head of that queue. A lost, duplicated or reordered response therefore shows up as a mismatch. A response that arrives with nothing queued is also reported.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

  localparam int W     = 32;
  localparam int POS_W = $clog2(W);
  localparam int SZ_W  = POS_W + 1;

  typedef logic [W-1:0]     word_t;
  typedef logic [POS_W-1:0] pos_t;
  typedef logic [SZ_W-1:0]  fsize_t;

  typedef enum logic {
    MODE_EXTRACT = 1'b0,
    MODE_INSERT  = 1'b1
  } bfu_mode_e;

  // Width within 1..W and the low end not below bit 0.
  function automatic logic field_ok(pos_t left, fsize_t size);
    int l;
    int s;
    l = int'(left);
    s = int'(size);
    return (s >= 1) && (s <= W) && (l - s + 1 >= 0);
  endfunction

  // Index of the field's least significant bit.
  function automatic pos_t low_index(pos_t left, fsize_t size);
    fsize_t t;
    t = {1'b0, left} - size + fsize_t'(1);
    return t[POS_W-1:0];
  endfunction

  // Ones in the low 'size' bits.
  function automatic word_t width_mask(fsize_t size);
    if (int'(size) >= W) return '1;
    return (word_t'(1) << size) - word_t'(1);
  endfunction

  // Push the field's top bit to bit W-1, then pull it down with zero fill.
  function automatic word_t extract_field(word_t w, pos_t left, fsize_t size);
    word_t t;
    t = w << (W - 1 - int'(left));
    return t >> (W - int'(size));
  endfunction

  function automatic word_t merge_field(word_t dst, word_t src,
                                        word_t fmask, word_t wmask, pos_t lo);
    return (dst & ~fmask) | ((src & wmask) << lo);
  endfunction

endpackage

// File: rtl/bfu_decode.sv
module bfu_decode
  import bfu_pkg::*;
(
  input  pos_t   left,
  input  fsize_t size,
  output logic   legal,
  output pos_t   lo,
  output word_t  wmask,
  output word_t  fmask
);

  always_comb begin
    legal = field_ok(left, size);
    lo    = low_index(left, size);
    wmask = width_mask(size);
    fmask = wmask << lo;
  end

endmodule

// File: rtl/bfu_core.sv
module bfu_core
  import bfu_pkg::*;
(
  input  bfu_mode_e mode,
  input  pos_t      left,
  input  fsize_t    size,
  input  word_t     word,
  input  word_t     src,
  input  logic      legal,
  input  pos_t      lo,
  input  word_t     wmask,
  input  word_t     fmask,
  output word_t     result,
  output logic      err
);

  always_comb begin
    err    = !legal;
    result = word;
    if (legal) begin
      case (mode)
        MODE_EXTRACT: result = extract_field(word, left, size);
        MODE_INSERT:  result = merge_field(word, src, fmask, wmask, lo);
        default:      result = word;
      endcase
    end
  end

endmodule

// File: rtl/bfu_stage.sv
module bfu_stage
  import bfu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  output logic  in_ready,
  input  word_t in_data,
  input  logic  in_err,
  output logic  out_valid,
  input  logic  out_ready,
  output word_t out_data,
  output logic  out_err
);

  logic  valid_q;
  word_t data_q;
  logic  err_q;

  assign in_ready = !valid_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      err_q   <= 1'b0;
    end else if (in_valid && in_ready) begin
      valid_q <= 1'b1;
      data_q  <= in_data;
      err_q   <= in_err;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign out_err   = err_q;

endmodule

// File: rtl/bfu_top.sv
module bfu_top
  import bfu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_mode,
  input  logic [4:0]  req_left,
  input  logic [5:0]  req_size,
  input  logic [31:0] req_word,
  input  logic [31:0] req_src,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_data,
  output logic        rsp_err
);

  logic  legal_w;
  pos_t  lo_w;
  word_t wmask_w;
  word_t fmask_w;
  word_t result_w;
  logic  err_w;

  // Handshake events, named for the checker.
  logic accept_w;
  logic drain_w;
  logic stall_w;

  bfu_decode u_decode (
    .left  (pos_t'(req_left)),
    .size  (fsize_t'(req_size)),
    .legal (legal_w),
    .lo    (lo_w),
    .wmask (wmask_w),
    .fmask (fmask_w)
  );

  bfu_core u_core (
    .mode   (bfu_mode_e'(req_mode)),
    .left   (pos_t'(req_left)),
    .size   (fsize_t'(req_size)),
    .word   (req_word),
    .src    (req_src),
    .legal  (legal_w),
    .lo     (lo_w),
    .wmask  (wmask_w),
    .fmask  (fmask_w),
    .result (result_w),
    .err    (err_w)
  );

  bfu_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (result_w),
    .in_err    (err_w),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (rsp_data),
    .out_err   (rsp_err)
  );

  assign accept_w = req_valid && req_ready;
  assign drain_w  = rsp_valid && rsp_ready;
  assign stall_w  = rsp_valid && !rsp_ready;

endmodule

// File: rtl/bfu_chk.sv
module bfu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        req_mode,
  input logic [4:0]  req_left,
  input logic [5:0]  req_size,
  input logic [31:0] req_word,
  input logic        rsp_valid,
  input logic [31:0] rsp_data,
  input logic        rsp_err,
  input logic        accept_w,
  input logic        drain_w,
  input logic        stall_w
);

  logic chk_legal;
  assign chk_legal = (req_size != 6'd0) && (req_size <= 6'd32) &&
                     ({2'b00, req_left} + 7'd1 >= {1'b0, req_size});

  // R7
  rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> rsp_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_w |=> rsp_valid && $stable(rsp_data) && $stable(rsp_err));

  // R8
  stall_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_w |-> !req_ready);

  // R10
  drain_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_w && !accept_w |=> !rsp_valid);

  // R6
  illegal_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w && !chk_legal |=> rsp_err && (rsp_data == $past(req_word)));

  // R1
  extract_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w && chk_legal && !req_mode |=>
      !rsp_err && ((rsp_data >> $past(req_size)) == 32'd0));

  // R2
  insert_upper_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w && chk_legal && req_mode |=>
      (rsp_data >> (32'($past(req_left)) + 32'd1)) ==
      ($past(req_word) >> (32'($past(req_left)) + 32'd1)));

endmodule

bind bfu_top bfu_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .req_mode  (req_mode),
  .req_left  (req_left),
  .req_size  (req_size),
  .req_word  (req_word),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .rsp_err   (rsp_err),
  .accept_w  (accept_w),
  .drain_w   (drain_w),
  .stall_w   (stall_w)
);

// File: tb/bfu_top_tb.sv
`timescale 1ns/1ps
module bfu_top_tb;

  localparam int NREQ = 3000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_mode;
  logic [4:0]  req_left;
  logic [5:0]  req_size;
  logic [31:0] req_word;
  logic [31:0] req_src;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [31:0] rsp_data;
  logic        rsp_err;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  bfu_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_left(req_left), .req_size(req_size),
    .req_word(req_word), .req_src(req_src), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err)
  );

  // Bit-by-bit model: {err, data}.
  function automatic logic [32:0] model(logic mode, logic [4:0] left,
                                        logic [5:0] size, logic [31:0] w,
                                        logic [31:0] s);
    int l;
    int n;
    int lo;
    logic [31:0] r;
    l = int'(left);
    n = int'(size);
    if (n < 1 || n > 32 || l - n + 1 < 0) return {1'b1, w};
    lo = l - n + 1;
    r = mode ? w : 32'd0;
    for (int i = 0; i < n; i++) begin
      if (mode) r[lo + i] = s[i];
      else      r[i] = w[lo + i];
    end
    return {1'b0, r};
  endfunction

  function automatic string pick_tag(logic mode, logic [4:0] left,
                                     logic [5:0] size, logic [31:0] s);
    int l;
    int n;
    l = int'(left);
    n = int'(size);
    if (n < 1 || n > 32 || l - n + 1 < 0) return "R6";
    if (n == 32) return "R4";
    if (l >= 16) return "R5";
    if (mode && ((s >> n) != 0)) return "R3";
    if (mode) return "R2";
    return "R1";
  endfunction

  task automatic check(bit ok, string tag, logic [32:0] act, logic [32:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic gen(int idx);
    int n;
    req_src = $urandom;
    req_word = $urandom;
    req_mode = 1'($urandom % 2);
    case (idx)
      0:  begin req_mode = 0; req_word = 32'h3B9ACA00; req_left = 9;  req_size = 8;  end
      1:  begin req_mode = 1; req_word = 32'hFFFFFFFF; req_src = 32'h5A; req_left = 9; req_size = 8; end
      2:  begin req_mode = 1; req_word = 32'h0; req_src = 32'hFFFFFF12; req_left = 9; req_size = 8; end
      3:  begin req_mode = 0; req_left = 31; req_size = 32; end
      4:  begin req_mode = 1; req_left = 31; req_size = 32; end
      5:  begin req_mode = 0; req_word = 32'h80000000; req_left = 31; req_size = 1; end
      6:  begin req_mode = 1; req_word = 32'h0000FFFF; req_src = 32'h0000BEEF; req_left = 31; req_size = 16; end
      7:  begin req_left = 5;  req_size = 0;  end
      8:  begin req_left = 31; req_size = 33; end
      9:  begin req_left = 3;  req_size = 8;  end
      10: begin req_mode = 0; req_word = 32'h1; req_left = 0; req_size = 1; end
      11: begin req_mode = 1; req_word = 32'hFFFFFFFE; req_src = 32'hFFFFFFFF; req_left = 0; req_size = 1; end
      default: begin
        if ($urandom % 10 == 0) begin
          req_size = 6'($urandom);
          req_left = 5'($urandom);
        end else begin
          n = 1 + int'($urandom % 32);
          req_size = 6'(n);
          req_left = 5'(n - 1 + int'($urandom % (33 - n)));
        end
      end
    endcase
  endtask

  initial begin
    int nreq;
    bit took;
    bit lat_pending;
    bit hold_pending;
    logic [32:0] hold_val;
    logic [32:0] e;
    string t;
    void'($urandom(32'd4242));
    nreq = 0; took = 0; lat_pending = 0; hold_pending = 0; hold_val = '0;
    rst_n = 0; req_valid = 0; req_mode = 0; req_left = 0; req_size = 0;
    req_word = 0; req_src = 0; rsp_ready = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R9
    check(!rsp_valid && req_ready, "R9", {31'd0, rsp_valid, req_ready}, 33'd1);
    for (int cyc = 0; cyc < 60000; cyc++) begin
      @(negedge clk);
      if (lat_pending) check(rsp_valid, "R7", {32'd0, rsp_valid}, 33'd1);
      if (hold_pending)
        check(rsp_valid && ({rsp_err, rsp_data} == hold_val), "R8",
              {rsp_err, rsp_data}, hold_val);
      lat_pending = 0;
      hold_pending = 0;
      if (!req_valid || took) begin
        if (nreq < NREQ && ($urandom % 5 != 0)) begin
          gen(nreq);
          nreq++;
          req_valid = 1;
        end else req_valid = 0;
      end
      rsp_ready = (nreq >= NREQ) ? 1'b1 : ($urandom % 10 < 7);
      #1;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R10", {rsp_err, rsp_data}, 33'd0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({rsp_err, rsp_data} == e, t, {rsp_err, rsp_data}, e);
        end
      end else if (rsp_valid) begin
        // R8: stalled output blocks new requests
        check(!req_ready, "R8", {32'd0, req_ready}, 33'd0);
        hold_pending = 1;
        hold_val = {rsp_err, rsp_data};
      end
      took = req_valid && req_ready;
      if (took) begin
        exp_q.push_back(model(req_mode, req_left, req_size, req_word, req_src));
        tag_q.push_back(pick_tag(req_mode, req_left, req_size, req_src));
        lat_pending = 1;
      end
      if (nreq >= NREQ && !took && !req_valid && exp_q.size() == 0 && !rsp_valid) break;
    end
    // R10: every accepted request produced exactly one response
    check(exp_q.size() == 0 && nreq == NREQ, "R10",
          33'(exp_q.size()), 33'd0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule